// File: doc/BRIEF.md
# Hardware Thread Selector for a Shared Issue Slot

This block decides, cycle by cycle, which of several hardware threads feeds the next instruction into a single-issue pipeline that all threads share. Each thread has its own program counter held inside the block. The counter of the selected thread drives fetch. It steps forward on every instruction issued from that thread, and it loads a target when a redirect for that thread arrives.

Two scheduling policies are available at run time. In interleaved mode a new thread may be chosen on every clock. The block rotates among the threads that can run and skips any that are stalled. In switch-on-miss mode the block keeps issuing from one thread until that thread reports a long-latency miss. It then raises a flush/freeze request and issues nothing until the pipeline reports that it is empty. After that it hands the issue slot to the next runnable thread, which resumes from its own saved counter. A per-thread preference bit lets favoured threads take precedence. A small saturating counter reports how long the last drain took.

Top module: `tsel_ctrl`

## Requirements
- R1: While reset is held and right after it is released, the block is in interleaved mode (`mode_eff` = 0), `sel_tid` is 0, every thread PC is 0, and `flush_req` and `drain_cnt` are 0. With no thread ready, `issue_valid` is 0.
- R2: In interleaved mode, a thread is eligible when its ready bit is 1 and its stall bit is 0. Each cycle the block selects the first eligible thread found by counting upward, with wrap-around, from the thread after the one that issued last. The last issuer itself is checked last. A selection is made every cycle, with no idle cycle between changes of thread.
- R3: In interleaved mode, a stalled or not-ready thread is never selected. When no thread is eligible, `issue_valid` is 0 and `sel_tid` stays on the last issuer.
- R4: When a thread's preference bit (`thr_prio`) is 1 and that thread is a candidate, only preferred candidates are considered. This holds for every interleaved choice and for the choice made at the end of a drain.
- R5: `fetch_pc` equals the PC of the thread shown on `sel_tid`. Each instruction issued from a thread, without a redirect for that thread in the same cycle, adds 4 to that thread's PC.
- R6: When `redir_vld[t]` is 1, thread t's PC loads `redir_pc[t*32 +: 32]` at the next edge. This happens whether or not thread t issues in that cycle, and it replaces the increment.
- R7: In switch-on-miss mode, `sel_tid` stays on the current thread. A stall bit on that thread only holds `issue_valid` at 0 for those cycles; it never causes a change of thread.
- R8: In switch-on-miss mode, a 1 on `thr_miss` for the current thread blocks issue in that cycle. From the next cycle `flush_req` is 1 and `issue_valid` is 0. Both hold until a cycle in which `pipe_empty` is 1 and a successor thread exists.
- R9: The successor is taken in rotation after the current thread, among threads that are eligible and have no miss pending. The current thread is considered last. If there is no such thread, the drain continues until one appears; this includes the current thread once its miss clears.
- R10: `drain_cnt` is cleared when a drain begins and grows by 1 for each cycle in which `flush_req` is 1, stopping at 15. It holds its value after the drain ends.
- R11: A new value on `mode_req` is taken into `mode_eff` only at an edge where `pipe_empty` is 1, no drain is in progress, and no drain is starting. A value of 1 selects switch-on-miss mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_req | input | 1 | Requested policy: 0 interleaved, 1 switch-on-miss |
| thr_ready | input | 4 | Per-thread has an instruction to issue |
| thr_stall | input | 4 | Per-thread short stall |
| thr_miss | input | 4 | Per-thread long-latency miss pending |
| thr_prio | input | 4 | Per-thread preference bit |
| pipe_empty | input | 1 | Pipeline holds no in-flight instruction |
| redir_vld | input | 4 | Per-thread next-PC load strobe |
| redir_pc | input | 128 | Per-thread redirect target, thread t in bits t*32+31..t*32 |
| sel_tid | output | 2 | Thread chosen this cycle |
| fetch_pc | output | 32 | PC of the chosen thread |
| issue_valid | output | 1 | An instruction issues from `sel_tid` this cycle |
| flush_req | output | 1 | Flush/freeze request while draining |
| drain_cnt | output | 4 | Saturating length of the latest drain |
| mode_eff | output | 1 | Policy currently in force |

## Verification
Interleaved mode is driven with several hundred cycles of seeded random ready, stall, preference and redirect patterns. These show whether rotation order, stall skipping, preference masking and per-thread counter updates all agree with an independent model. Directed sequences then exercise the switch-on-miss policy. A short stall must not move the selection, while a miss must start a drain that holds until the pipeline is empty. A drain longer than 15 cycles separates saturation from wrap-around. A drain that finds no successor tells apart the "resume the same thread" path from a premature exit. A preferred thread that is not next in rotation shows that preference takes part in the successor choice. Mode requests made while the pipeline is busy check that a policy change waits for an empty pipeline.

// File: rtl/tsel_pkg.sv
package tsel_pkg;
   typedef enum logic {
      ST_RUN   = 1'b0,
      ST_DRAIN = 1'b1
   } tsel_st_e;
endpackage

// File: rtl/tsel_rr_pick.sv
// Rotating first-hit picker with a preference mask.
module tsel_rr_pick #(
   parameter int NTHR = 4,
   localparam int TIDW = $clog2(NTHR)
) (
   input  logic [NTHR-1:0] req,
   input  logic [NTHR-1:0] prio,
   input  logic [TIDW-1:0] base,
   output logic [TIDW-1:0] pick,
   output logic            found
);
   logic [NTHR-1:0] cand;
   logic [TIDW-1:0] idx;

   always_comb begin
      cand  = ((req & prio) != '0) ? (req & prio) : req;
      found = (cand != '0);
      pick  = base;
      idx   = base;
      // scan from farthest to nearest so the nearest hit wins
      for (int k = NTHR; k >= 1; k--) begin
         idx = base + TIDW'(k);
         if (cand[idx]) pick = idx;
      end
   end
endmodule

// File: rtl/tsel_pc_bank.sv
// One program counter per thread.
module tsel_pc_bank #(
   parameter int NTHR    = 4,
   parameter int PCW     = 32,
   parameter int PC_STEP = 4,
   localparam int TIDW = $clog2(NTHR)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      issue,
   input  logic [TIDW-1:0]           sel,
   input  logic [NTHR-1:0]           redir_vld,
   input  logic [NTHR-1:0][PCW-1:0]  redir_pc,
   output logic [NTHR-1:0][PCW-1:0]  pc_q
);
   generate
      for (genvar t = 0; t < NTHR; t++) begin : g_pc
         always_ff @(posedge clk) begin
            if (!rst_n)
               pc_q[t] <= '0;
            else if (redir_vld[t])
               pc_q[t] <= redir_pc[t];
            else if (issue && (sel == TIDW'(t)))
               pc_q[t] <= pc_q[t] + PCW'(PC_STEP);
         end
      end
   endgenerate
endmodule

// File: rtl/tsel_ctrl.sv
module tsel_ctrl #(
   parameter int NTHR    = 4,
   parameter int PCW     = 32,
   parameter int PC_STEP = 4,
   parameter int DCW     = 4,
   localparam int TIDW = $clog2(NTHR)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  mode_req,
   input  logic [NTHR-1:0]       thr_ready,
   input  logic [NTHR-1:0]       thr_stall,
   input  logic [NTHR-1:0]       thr_miss,
   input  logic [NTHR-1:0]       thr_prio,
   input  logic                  pipe_empty,
   input  logic [NTHR-1:0]       redir_vld,
   input  logic [NTHR*PCW-1:0]   redir_pc,
   output logic [TIDW-1:0]       sel_tid,
   output logic [PCW-1:0]        fetch_pc,
   output logic                  issue_valid,
   output logic                  flush_req,
   output logic [DCW-1:0]        drain_cnt,
   output logic                  mode_eff
);
   import tsel_pkg::*;

   localparam logic [DCW-1:0] DMAX = {DCW{1'b1}};

   generate
      if (NTHR < 2 || (NTHR & (NTHR - 1)) != 0) begin : g_bad_nthr
         $error("NTHR must be a power of two, at least 2");
      end
      if (DCW < 1 || PCW < 2) begin : g_bad_width
         $error("DCW and PCW out of range");
      end
   endgenerate

   tsel_st_e                  st_q;
   logic [TIDW-1:0]           cur_q;
   logic [DCW-1:0]            dcnt_q;
   logic                      mode_q;
   logic [NTHR-1:0]           elig, cand_req;
   logic [TIDW-1:0]           pick;
   logic                      found, trig;
   logic [NTHR-1:0][PCW-1:0]  rpc, pcs;

   assign rpc      = redir_pc;
   assign elig     = thr_ready & ~thr_stall;
   assign cand_req = mode_q ? (elig & ~thr_miss) : elig;
   assign trig     = mode_q && (st_q == ST_RUN) && thr_miss[cur_q];

   tsel_rr_pick #(.NTHR(NTHR)) u_pick (
      .req   (cand_req),
      .prio  (thr_prio),
      .base  (cur_q),
      .pick  (pick),
      .found (found)
   );

   always_comb begin
      if (!mode_q) begin
         sel_tid     = pick;
         issue_valid = found;
         flush_req   = 1'b0;
      end else if (st_q == ST_RUN) begin
         sel_tid     = cur_q;
         issue_valid = elig[cur_q] && !thr_miss[cur_q];
         flush_req   = 1'b0;
      end else begin
         sel_tid     = cur_q;
         issue_valid = 1'b0;
         flush_req   = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_RUN;
         cur_q  <= '0;
         dcnt_q <= '0;
         mode_q <= 1'b0;
      end else begin
         if (!mode_q) begin
            if (found) cur_q <= pick;
         end else if (st_q == ST_RUN) begin
            if (trig) begin
               st_q   <= ST_DRAIN;
               dcnt_q <= '0;
            end
         end else begin
            if (dcnt_q != DMAX) dcnt_q <= dcnt_q + 1'b1;
            if (pipe_empty && found) begin
               cur_q <= pick;
               st_q  <= ST_RUN;
            end
         end
         if ((st_q == ST_RUN) && !trig && pipe_empty)
            mode_q <= mode_req;
      end
   end

   tsel_pc_bank #(.NTHR(NTHR), .PCW(PCW), .PC_STEP(PC_STEP)) u_pcs (
      .clk       (clk),
      .rst_n     (rst_n),
      .issue     (issue_valid),
      .sel       (sel_tid),
      .redir_vld (redir_vld),
      .redir_pc  (rpc),
      .pc_q      (pcs)
   );

   assign fetch_pc  = pcs[sel_tid];
   assign drain_cnt = dcnt_q;
   assign mode_eff  = mode_q;
endmodule

// File: rtl/tsel_ctrl_chk.sv
module tsel_ctrl_chk #(
   parameter int NTHR = 4,
   parameter int DCW  = 4,
   localparam int TIDW = $clog2(NTHR)
) (
   input logic            clk,
   input logic            rst_n,
   input logic [NTHR-1:0] thr_ready,
   input logic [NTHR-1:0] thr_stall,
   input logic [NTHR-1:0] thr_prio,
   input logic            pipe_empty,
   input logic [TIDW-1:0] sel_tid,
   input logic            issue_valid,
   input logic            flush_req,
   input logic [DCW-1:0]  drain_cnt,
   input logic            mode_eff
);
   assert_flush_blocks_issue_R8: assert property (@(posedge clk) disable iff (!rst_n)
      flush_req |-> !issue_valid);

   assert_flush_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_req && !pipe_empty) |=> flush_req);

   assert_fine_skips_stalled_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && !mode_eff) |-> (thr_ready[sel_tid] && !thr_stall[sel_tid]));

   assert_pref_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && !mode_eff && ((thr_ready & ~thr_stall & thr_prio) != '0))
         |-> thr_prio[sel_tid]);

   assert_coarse_stays_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_eff && $past(mode_eff) && !flush_req && !$past(flush_req))
         |-> (sel_tid == $past(sel_tid)));

   assert_drain_saturates_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_req && (drain_cnt == {DCW{1'b1}})) |=> (drain_cnt == {DCW{1'b1}}));

   assert_mode_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_eff != $past(mode_eff)) |-> ($past(pipe_empty) && !$past(flush_req)));
endmodule

bind tsel_ctrl tsel_ctrl_chk #(.NTHR(NTHR), .DCW(DCW)) u_chk (.*);

// File: tb/sim_tsel_ctrl.sv
module sim_tsel_ctrl;
   localparam int N = 4;
   localparam int W = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic           mode_req = 1'b0;
   logic [N-1:0]   rdy = '0, stl = '0, mis = '0, pri = '0, rv = '0;
   logic           pe = 1'b0;
   logic [N*W-1:0] rpc = '0;

   logic [1:0]     sel_tid;
   logic [W-1:0]   fetch_pc;
   logic           issue_valid, flush_req, mode_eff;
   logic [3:0]     drain_cnt;

   tsel_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .mode_req(mode_req),
      .thr_ready(rdy), .thr_stall(stl), .thr_miss(mis), .thr_prio(pri),
      .pipe_empty(pe), .redir_vld(rv), .redir_pc(rpc),
      .sel_tid(sel_tid), .fetch_pc(fetch_pc), .issue_valid(issue_valid),
      .flush_req(flush_req), .drain_cnt(drain_cnt), .mode_eff(mode_eff)
   );

   int n_cmp = 0, n_bad = 0;
   bit done = 0;
   logic [W-1:0] m_pc [N];
   int m_last = 0;

   task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int pick_fn(int base, logic [N-1:0] req, logic [N-1:0] pr);
      logic [N-1:0] c;
      c = ((req & pr) != '0) ? (req & pr) : req;
      for (int k = 1; k <= N; k++) begin
         if (c[(base + k) % N]) return (base + k) % N;
      end
      return -1;
   endfunction

   // inputs already driven at posedge+1; sample at the falling edge
   task automatic cyc(string tag, bit ei, int et, bit ef);
      #4;
      chk({tag, " issue"}, W'(issue_valid), W'(ei));
      chk({tag, " tid"},   W'(sel_tid),     W'(et));
      chk({tag, " flush"}, W'(flush_req),   W'(ef));
      chk({tag, " pc"},    fetch_pc,        m_pc[et]);
      for (int t = 0; t < N; t++) begin
         if (rv[t]) m_pc[t] = rpc[t*W +: W];
         else if (ei && t == et) m_pc[t] = m_pc[t] + 4;
      end
      @(posedge clk);
      #1;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      for (int t = 0; t < N; t++) m_pc[t] = '0;
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      chk("R1 tid", W'(sel_tid), 0);
      chk("R1 pc", fetch_pc, 0);
      chk("R1 issue", W'(issue_valid), 0);
      chk("R1 flush", W'(flush_req), 0);
      chk("R1 drain", W'(drain_cnt), 0);
      chk("R1 mode", W'(mode_eff), 0);
      rst_n = 1'b1;
      #1;
      chk("R1 tid after release", W'(sel_tid), 0);
      @(posedge clk);
      #1;

      // random interleaved phase: R2 R3 R4 R5 R6
      for (int i = 0; i < 400; i++) begin
         int p;
         rdy = N'($urandom());
         stl = N'($urandom()) & N'($urandom());
         pri = ($urandom() % 4 == 0) ? N'($urandom()) : '0;
         rv  = ($urandom() % 8 == 0) ? N'($urandom()) : '0;
         for (int t = 0; t < N; t++) rpc[t*W +: W] = $urandom() & 32'hFFFF_FFFC;
         pe  = 1'(($urandom()));
         p = pick_fn(m_last, rdy & ~stl, pri);
         cyc("R2_R3_R4_R5_R6 fine", p >= 0, (p >= 0) ? p : m_last, 0);
         if (p >= 0) m_last = p;
      end

      // directed: land on thread 2 (R2), then no one ready (R3)
      rdy = 4'b0100; stl = '0; pri = '0; rv = '0; pe = 1'b0;
      cyc("R2", 1, 2, 0);
      m_last = 2;
      rdy = '0; mode_req = 1'b1;
      for (int i = 0; i < 3; i++) begin
         cyc("R3 none ready", 0, 2, 0);
         chk("R11 mode held while busy", W'(mode_eff), 0);
      end
      pe = 1'b1;
      cyc("R11", 0, 2, 0);
      chk("R11 mode taken when empty", W'(mode_eff), 1);

      // R7 switch-on-miss stays on thread 2, short stall does not switch
      pe = 1'b0; rdy = 4'hF;
      for (int i = 0; i < 4; i++) cyc("R7", 1, 2, 0);
      stl = 4'b0100;
      cyc("R7 short stall", 0, 2, 0);
      cyc("R7 short stall", 0, 2, 0);
      stl = '0;
      cyc("R7", 1, 2, 0);

      // R8 miss on thread 2, drain three busy cycles, then R9 successor 0
      mis = 4'b0100;
      cyc("R8 trigger", 0, 2, 0);
      for (int i = 0; i < 3; i++) cyc("R8 draining", 0, 2, 1);
      pe = 1'b1; stl = 4'b1000;
      cyc("R9 exit", 0, 2, 1);
      chk("R10 drain length", W'(drain_cnt), 4);
      pe = 1'b0; stl = '0; mis = '0;
      cyc("R9 successor", 1, 0, 0);

      // R10 saturation, R9 no successor until own miss clears
      mis = 4'b0001;
      cyc("R8 trigger", 0, 0, 0);
      for (int i = 0; i < 20; i++) cyc("R10 long drain", 0, 0, 1);
      chk("R10 saturated", W'(drain_cnt), 15);
      pe = 1'b1; stl = 4'b1110;
      cyc("R9 no successor", 0, 0, 1);
      cyc("R9 no successor", 0, 0, 1);
      mis = '0;
      cyc("R9 resume same", 0, 0, 1);
      chk("R10 held after drain", W'(drain_cnt), 15);
      pe = 1'b0; stl = '0;
      cyc("R9 resume same", 1, 0, 0);

      // R4 preference in successor choice
      pri = 4'b1000; mis = 4'b0001; pe = 1'b1;
      cyc("R8 trigger", 0, 0, 0);
      cyc("R4 exit", 0, 0, 1);
      chk("R10 short drain", W'(drain_cnt), 1);
      mis = '0; pe = 1'b0;
      cyc("R4 preferred successor", 1, 3, 0);

      // R6 redirect while issuing and for an idle thread, R5 step
      rv = 4'b1000; rpc[3*W +: W] = 32'h0000_1000;
      cyc("R6", 1, 3, 0);
      rv = 4'b0010; rpc[1*W +: W] = 32'h0000_2220;
      cyc("R6 loaded", 1, 3, 0);
      rv = '0;
      cyc("R5 step", 1, 3, 0);

      // back to interleaved, R11 and R2 rotation from thread 3
      mode_req = 1'b0; pe = 1'b1; pri = '0;
      cyc("R11", 1, 3, 0);
      chk("R11 back to interleaved", W'(mode_eff), 0);
      m_last = 3; pe = 1'b0;
      cyc("R2 wrap", 1, 0, 0);
      cyc("R2 next", 1, 1, 0);
      cyc("R2 next", 1, 2, 0);

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule